// File: doc/BRIEF.md
# Five-State Snooping Line Coherence Controller

This block holds the coherence state of every line in a small private cache and decides how each line reacts to its own processor and to traffic that other caches put on a shared bus. Each line is Invalid, Shared, Exclusive, Owned or Modified. A local read, write or eviction can change the line's state and can make the block issue one bus transaction. A snooped transaction from another cache can downgrade or invalidate the line. When that happens the block reports that it holds a copy, and it reports when it must supply the data itself.

The Owned state lets a dirty line be read by other caches without first updating memory. This cache keeps the dirty data and stays responsible for the final write-back, and it also serves later snooped reads of that line. The block contains no data array and no bus arbiter. It computes the state transitions and the bus responses, registers them, and shows every line's current state on a flat vector.

In any cycle the block accepts one local request and one snooped transaction. If both name the same line, the snooped transaction is ordered first.

Top module: `moesi_coherence_ctrl`

## Requirements
- R1: After synchronous reset every line reads Invalid, and bus_req_valid, snp_shared_out, snp_supply_out and cpu_hit are low. State codes are I=0, S=1, E=2, O=3, M=4, and line i occupies state_vec[3i+2:3i].
- R2: A local read (cpu_op 0) of an Invalid line issues a bus read (bus_req_op 0). The line becomes E if bus_shared_in was low with the request, and S if it was high. cpu_hit stays low. A read of a valid line issues nothing, leaves the state unchanged and raises cpu_hit.
- R3: A local write (cpu_op 1) always leaves the line in M. From I it issues read-for-ownership (bus_req_op 1). From S or O it issues an invalidate (bus_req_op 2). From E or M it issues nothing. cpu_hit is high unless the line was I.
- R4: A snooped read (snp_op 0) of a valid line raises snp_shared_out. M moves to O and E moves to S, while S and O keep their state. Only M and O raise snp_supply_out.
- R5: A snooped read-for-ownership (snp_op 1) or invalidate (snp_op 2) moves any valid line to I. A line in M or O raises snp_supply_out. snp_shared_out stays low.
- R6: A snoop that targets an Invalid line, or any snooped write-back (snp_op 3), changes no state and raises neither snp_shared_out nor snp_supply_out.
- R7: An eviction (cpu_op 2) of an M or O line issues a write-back (bus_req_op 3). An eviction of an E or S line drops it silently. In every case the line ends in I.
- R8: All responses are registered. They appear in the cycle after the request is sampled, together with the updated state, and bus_req_line repeats the requested line. The block issues no bus request without a local request.
- R9: When a local request and a snoop arrive in the same cycle for the same line, the local request acts on the state the snoop leaves behind. When they name different lines, each acts independently.
- R10: cpu_op 3 is a no-operation. It changes no state, issues no request and leaves cpu_hit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 no-op |
| cpu_line | input | IDX_W | Line index of the local request |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with a local request |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped op: 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| snp_line | input | IDX_W | Line index of the snooped transaction |
| bus_req_valid | output | 1 | Bus transaction issued |
| bus_req_op | output | 2 | Issued op: 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_line | output | IDX_W | Line of the issued transaction |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_supply_out | output | 1 | This cache must supply the snooped line's data |
| cpu_hit | output | 1 | Local read or write found a valid line |
| state_vec | output | 3*N_LINES | Current state of every line |

## Verification
The hardest case to reach is a snoop and a local request that hit the same line in the same cycle. In that case the snoop must act first and the local request must then see the state the snoop left, for example a write that finds its line just invalidated and has to issue read-for-ownership instead of an invalidate. Directed steps set up each such collision on purpose. The random phase draws both line indices from only four lines, so collisions in every starting state keep occurring.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        CPU_RD    = 2'd0,
        CPU_WR    = 2'd1,
        CPU_EVICT = 2'd2,
        CPU_NOP   = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        SNP_RD   = 2'd0,
        SNP_RDX  = 2'd1,
        SNP_UPGR = 2'd2,
        SNP_WB   = 2'd3
    } snp_op_e;

    typedef enum logic [1:0] {
        BUS_RD   = 2'd0,
        BUS_RDX  = 2'd1,
        BUS_UPGR = 2'd2,
        BUS_WB   = 2'd3
    } bus_op_e;

    typedef struct packed {
        line_state_e nxt;
        logic        shared;
        logic        supply;
    } snoop_resp_t;

    typedef struct packed {
        line_state_e nxt;
        logic        req;
        bus_op_e     op;
        logic        hit;
    } local_resp_t;

    function automatic logic is_valid(line_state_e s);
        return s != ST_I;
    endfunction

    function automatic logic is_dirty(line_state_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    // Reaction of one line to a transaction seen on the bus
    function automatic snoop_resp_t snoop_step(line_state_e s, snp_op_e op);
        snoop_resp_t r;
        r.nxt    = s;
        r.shared = 1'b0;
        r.supply = 1'b0;
        case (op)
            SNP_RD: begin
                r.shared = is_valid(s);
                r.supply = is_dirty(s);
                if (s == ST_M)      r.nxt = ST_O;
                else if (s == ST_E) r.nxt = ST_S;
            end
            SNP_RDX, SNP_UPGR: begin
                r.supply = is_dirty(s);
                r.nxt    = ST_I;
            end
            default: ;
        endcase
        return r;
    endfunction

    // Reaction of one line to its own processor
    function automatic local_resp_t local_step(line_state_e s, cpu_op_e op, logic others_hold);
        local_resp_t r;
        r.nxt = s;
        r.req = 1'b0;
        r.op  = BUS_RD;
        r.hit = 1'b0;
        case (op)
            CPU_RD: begin
                r.hit = is_valid(s);
                if (!is_valid(s)) begin
                    r.req = 1'b1;
                    r.op  = BUS_RD;
                    r.nxt = others_hold ? ST_S : ST_E;
                end
            end
            CPU_WR: begin
                r.hit = is_valid(s);
                r.nxt = ST_M;
                if (s == ST_I) begin
                    r.req = 1'b1;
                    r.op  = BUS_RDX;
                end else if (s == ST_S || s == ST_O) begin
                    r.req = 1'b1;
                    r.op  = BUS_UPGR;
                end
            end
            CPU_EVICT: begin
                r.nxt = ST_I;
                if (is_dirty(s)) begin
                    r.req = 1'b1;
                    r.op  = BUS_WB;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array
    import moesi_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  line_state_e [N_LINES-1:0] nxt_st,
    output line_state_e [N_LINES-1:0] cur_st
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) cur_st[i] <= ST_I;
            else     cur_st[i] <= nxt_st[i];
        end
    end
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
    import moesi_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic                      snp_valid,
    input  snp_op_e                   snp_op,
    input  logic [IDX_W-1:0]          snp_line,
    input  line_state_e [N_LINES-1:0] cur_st,
    output line_state_e [N_LINES-1:0] post_st,
    output logic                      shared,
    output logic                      supply
);
    logic [N_LINES-1:0] sh_bits;
    logic [N_LINES-1:0] sup_bits;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        snoop_resp_t resp;
        logic        sel;
        assign sel         = snp_valid && (snp_line == IDX_W'(i));
        assign resp        = snoop_step(cur_st[i], snp_op);
        assign post_st[i]  = sel ? resp.nxt : cur_st[i];
        assign sh_bits[i]  = sel && resp.shared;
        assign sup_bits[i] = sel && resp.supply;
    end

    assign shared = |sh_bits;
    assign supply = |sup_bits;
endmodule

// File: rtl/moesi_local_unit.sv
module moesi_local_unit
    import moesi_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic                      cpu_valid,
    input  cpu_op_e                   cpu_op,
    input  logic [IDX_W-1:0]          cpu_line,
    input  logic                      others_hold,
    input  line_state_e [N_LINES-1:0] post_st,
    output line_state_e [N_LINES-1:0] nxt_st,
    output logic                      req,
    output bus_op_e                   req_op,
    output logic                      hit
);
    local_resp_t sel_resp;

    // Acts on the state left by the snoop of the same cycle
    assign sel_resp = local_step(post_st[cpu_line], cpu_op, others_hold);
    assign req      = cpu_valid && sel_resp.req;
    assign req_op   = sel_resp.op;
    assign hit      = cpu_valid && sel_resp.hit;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign nxt_st[i] = (cpu_valid && cpu_line == IDX_W'(i)) ? sel_resp.nxt : post_st[i];
    end
endmodule

// File: rtl/moesi_coherence_ctrl.sv
module moesi_coherence_ctrl
    import moesi_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cpu_valid,
    input  logic [1:0]                 cpu_op,
    input  logic [IDX_W-1:0]           cpu_line,
    input  logic                       bus_shared_in,
    input  logic                       snp_valid,
    input  logic [1:0]                 snp_op,
    input  logic [IDX_W-1:0]           snp_line,
    output logic                       bus_req_valid,
    output logic [1:0]                 bus_req_op,
    output logic [IDX_W-1:0]           bus_req_line,
    output logic                       snp_shared_out,
    output logic                       snp_supply_out,
    output logic                       cpu_hit,
    output logic [STATE_W*N_LINES-1:0] state_vec
);
    line_state_e [N_LINES-1:0] cur_st;
    line_state_e [N_LINES-1:0] post_st;
    line_state_e [N_LINES-1:0] nxt_st;
    logic    shared_c, supply_c, req_c, hit_c;
    bus_op_e req_op_c;

    moesi_state_array #(.N_LINES(N_LINES)) u_array (
        .clk    (clk),
        .rst    (rst),
        .nxt_st (nxt_st),
        .cur_st (cur_st)
    );

    moesi_snoop_unit #(.N_LINES(N_LINES)) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (snp_op_e'(snp_op)),
        .snp_line  (snp_line),
        .cur_st    (cur_st),
        .post_st   (post_st),
        .shared    (shared_c),
        .supply    (supply_c)
    );

    moesi_local_unit #(.N_LINES(N_LINES)) u_local (
        .cpu_valid   (cpu_valid),
        .cpu_op      (cpu_op_e'(cpu_op)),
        .cpu_line    (cpu_line),
        .others_hold (bus_shared_in),
        .post_st     (post_st),
        .nxt_st      (nxt_st),
        .req         (req_c),
        .req_op      (req_op_c),
        .hit         (hit_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req_valid  <= 1'b0;
            bus_req_op     <= 2'd0;
            bus_req_line   <= '0;
            snp_shared_out <= 1'b0;
            snp_supply_out <= 1'b0;
            cpu_hit        <= 1'b0;
        end else begin
            bus_req_valid  <= req_c;
            bus_req_op     <= req_op_c;
            bus_req_line   <= cpu_line;
            snp_shared_out <= shared_c;
            snp_supply_out <= supply_c;
            cpu_hit        <= hit_c;
        end
    end

    assign state_vec = cur_st;
endmodule

// File: rtl/moesi_coherence_chk.sv
module moesi_coherence_chk #(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cpu_valid,
    input logic [1:0]             cpu_op,
    input logic [IDX_W-1:0]       cpu_line,
    input logic                   snp_valid,
    input logic [1:0]             snp_op,
    input logic [IDX_W-1:0]       snp_line,
    input logic                   bus_req_valid,
    input logic [1:0]             bus_req_op,
    input logic [IDX_W-1:0]       bus_req_line,
    input logic                   snp_shared_out,
    input logic                   snp_supply_out,
    input logic                   cpu_hit,
    input logic [3*N_LINES-1:0]   state_vec
);
    logic [2:0]       snp_pre_q, cpu_pre_q;
    logic [IDX_W-1:0] cpu_line_q;
    logic             cpu_v_q, cpu_wr_q, snp_rd_q;
    logic             any_illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_pre_q  <= 3'd0;
            cpu_pre_q  <= 3'd0;
            cpu_line_q <= '0;
            cpu_v_q    <= 1'b0;
            cpu_wr_q   <= 1'b0;
            snp_rd_q   <= 1'b0;
        end else begin
            snp_pre_q  <= state_vec[3*int'(snp_line) +: 3];
            cpu_pre_q  <= state_vec[3*int'(cpu_line) +: 3];
            cpu_line_q <= cpu_line;
            cpu_v_q    <= cpu_valid;
            cpu_wr_q   <= cpu_valid && cpu_op == 2'd1;
            snp_rd_q   <= snp_valid && snp_op == 2'd0;
        end
    end

    always_comb begin
        any_illegal = 1'b0;
        for (int i = 0; i < N_LINES; i++)
            if (state_vec[3*i +: 3] > 3'd4) any_illegal = 1'b1;
    end

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst) !any_illegal); // R1
    AST_SUPPLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
        snp_supply_out |-> (snp_pre_q == 3'd3 || snp_pre_q == 3'd4)); // R5
    AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (rst)
        snp_shared_out |-> snp_rd_q); // R4
    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_op == 2'd3) |-> (cpu_pre_q == 3'd3 || cpu_pre_q == 3'd4)); // R7
    AST_WRITE_ENDS_M: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_q |-> state_vec[3*int'(cpu_line_q) +: 3] == 3'd4); // R3
    AST_REQ_FROM_CPU: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (cpu_v_q && bus_req_line == cpu_line_q)); // R8
    AST_HIT_FROM_CPU: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> cpu_v_q); // R2
endmodule

bind moesi_coherence_ctrl moesi_coherence_chk #(.N_LINES(N_LINES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_valid      (cpu_valid),
    .cpu_op         (cpu_op),
    .cpu_line       (cpu_line),
    .snp_valid      (snp_valid),
    .snp_op         (snp_op),
    .snp_line       (snp_line),
    .bus_req_valid  (bus_req_valid),
    .bus_req_op     (bus_req_op),
    .bus_req_line   (bus_req_line),
    .snp_shared_out (snp_shared_out),
    .snp_supply_out (snp_supply_out),
    .cpu_hit        (cpu_hit),
    .state_vec      (state_vec)
);

// File: tb/moesi_coherence_ctrl_bench.sv
module moesi_coherence_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_valid, bus_shared_in, snp_valid;
    logic [1:0]    cpu_op, snp_op;
    logic [IW-1:0] cpu_line, snp_line;
    logic          bus_req_valid, snp_shared_out, snp_supply_out, cpu_hit;
    logic [1:0]    bus_req_op;
    logic [IW-1:0] bus_req_line;
    logic [3*N-1:0] state_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [2:0] exp_st [N];

    always #5 clk = ~clk;

    moesi_coherence_ctrl #(.N_LINES(N)) u_moesi_coherence_ctrl (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_line(bus_req_line),
        .snp_shared_out(snp_shared_out), .snp_supply_out(snp_supply_out), .cpu_hit(cpu_hit),
        .state_vec(state_vec)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3*N-1:0] pack_exp();
        logic [3*N-1:0] v;
        for (int i = 0; i < N; i++) v[3*i +: 3] = exp_st[i];
        return v;
    endfunction

    // One request cycle: drive, model, wait for the registered result, compare
    task automatic step(input bit cv, input logic [1:0] cop, input int cl, input bit sh,
                        input bit sv, input logic [1:0] sop, input int sl, input string tag);
        logic [2:0] s;
        bit e_sh, e_sup, e_req, e_hit;
        logic [1:0] e_op;
        cpu_valid = cv; cpu_op = cop; cpu_line = IW'(cl); bus_shared_in = sh;
        snp_valid = sv; snp_op = sop; snp_line = IW'(sl);
        e_sh = 0; e_sup = 0; e_req = 0; e_hit = 0; e_op = 0;
        if (sv) begin
            s = exp_st[sl];
            if (sop == 2'd0) begin
                e_sh  = (s != 0);
                e_sup = (s == 3 || s == 4);
                if (s == 4) exp_st[sl] = 3;
                if (s == 2) exp_st[sl] = 1;
            end else if (sop == 2'd1 || sop == 2'd2) begin
                e_sup = (s == 3 || s == 4);
                exp_st[sl] = 0;
            end
        end
        if (cv) begin
            s = exp_st[cl];
            case (cop)
                2'd0: begin
                    e_hit = (s != 0);
                    if (s == 0) begin e_req = 1; e_op = 0; exp_st[cl] = sh ? 3'd1 : 3'd2; end
                end
                2'd1: begin
                    e_hit = (s != 0);
                    if (s == 0) begin e_req = 1; e_op = 1; end
                    else if (s == 1 || s == 3) begin e_req = 1; e_op = 2; end
                    exp_st[cl] = 4;
                end
                2'd2: begin
                    if (s == 3 || s == 4) begin e_req = 1; e_op = 3; end
                    exp_st[cl] = 0;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(state_vec == pack_exp(), tag, "state_vec", 32'(state_vec), 32'(pack_exp()));
        check(bus_req_valid == e_req, tag, "bus_req_valid", 32'(bus_req_valid), 32'(e_req));
        if (e_req) begin
            check(bus_req_op == e_op, tag, "bus_req_op", 32'(bus_req_op), 32'(e_op));
            check(bus_req_line == IW'(cl), tag, "bus_req_line", 32'(bus_req_line), 32'(cl));
        end
        check(snp_shared_out == e_sh, tag, "snp_shared_out", 32'(snp_shared_out), 32'(e_sh));
        check(snp_supply_out == e_sup, tag, "snp_supply_out", 32'(snp_supply_out), 32'(e_sup));
        check(cpu_hit == e_hit, tag, "cpu_hit", 32'(cpu_hit), 32'(e_hit));
    endtask

    task automatic cpu(input logic [1:0] op, input int l, input bit sh, input string tag);
        step(1, op, l, sh, 0, 2'd0, 0, tag);
    endtask

    task automatic snp(input logic [1:0] op, input int l, input string tag);
        step(0, 2'd0, 0, 0, 1, op, l, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1; cpu_valid = 0; cpu_op = 0; cpu_line = 0; bus_shared_in = 0;
        snp_valid = 0; snp_op = 0; snp_line = 0;
        for (int i = 0; i < N; i++) exp_st[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(state_vec == '0, "R1", "state_vec", 32'(state_vec), 0);
        check(!bus_req_valid && !snp_shared_out && !snp_supply_out && !cpu_hit,
              "R1", "outputs", {28'd0, bus_req_valid, snp_shared_out, snp_supply_out, cpu_hit}, 0);

        // R2: read misses and hits
        cpu(2'd0, 0, 0, "R2");
        cpu(2'd0, 1, 1, "R2");
        cpu(2'd0, 0, 1, "R2");
        // R3: writes from each start state
        cpu(2'd1, 0, 0, "R3");
        cpu(2'd1, 1, 0, "R3");
        cpu(2'd1, 2, 0, "R3");
        cpu(2'd1, 0, 0, "R3");
        // R4: snooped reads
        snp(2'd0, 0, "R4");
        snp(2'd0, 0, "R4");
        cpu(2'd0, 3, 0, "R4");
        snp(2'd0, 3, "R4");
        snp(2'd0, 3, "R4");
        cpu(2'd1, 0, 0, "R3");
        // R5: ownership and invalidate snoops
        snp(2'd1, 0, "R5");
        snp(2'd2, 1, "R5");
        cpu(2'd0, 4, 0, "R5");
        snp(2'd2, 4, "R5");
        snp(2'd1, 3, "R5");
        // R6: snoops that change nothing
        snp(2'd0, 5, "R6");
        snp(2'd3, 2, "R6");
        snp(2'd1, 5, "R6");
        // R7: evictions
        cpu(2'd2, 2, 0, "R7");
        cpu(2'd1, 6, 0, "R7");
        snp(2'd0, 6, "R7");
        cpu(2'd2, 6, 0, "R7");
        cpu(2'd0, 7, 0, "R7");
        cpu(2'd2, 7, 0, "R7");
        cpu(2'd0, 7, 1, "R7");
        cpu(2'd2, 7, 0, "R7");
        cpu(2'd2, 7, 0, "R7");
        // R9: same-cycle collisions
        cpu(2'd0, 2, 1, "R9");
        step(1, 2'd1, 2, 0, 1, 2'd1, 2, "R9");
        step(1, 2'd1, 2, 0, 1, 2'd0, 2, "R9");
        step(1, 2'd2, 2, 0, 1, 2'd0, 2, "R9");
        cpu(2'd0, 1, 0, "R9");
        step(1, 2'd1, 1, 0, 1, 2'd0, 1, "R9");
        step(1, 2'd0, 5, 0, 1, 2'd0, 1, "R9");
        // R10: no-operation
        step(1, 2'd3, 1, 1, 0, 2'd0, 0, "R10");
        step(1, 2'd3, 5, 0, 0, 2'd0, 0, "R10");
        // R8: random mix on four lines so collisions recur
        for (int k = 0; k < 3000; k++) begin
            step($urandom % 4 != 0, 2'($urandom % 4), int'($urandom % 4), $urandom % 2 == 1,
                 $urandom % 3 == 0, 2'($urandom % 4), int'($urandom % 4), "R8");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule